// File: doc/BRIEF.md
# Digitizer Trigger Mode Detector

This block decides when a two-channel digitizer starts recording. It watches two streams of signed 8-bit samples and one external logic-level input, and produces a single-cycle trigger event according to a 4-bit mode code. The modes are:

- an immediate start from software;
- a rising or falling threshold crossing on either channel;
- a rising or falling edge on the external input;
- gated sampling, active while the external input sits at a chosen level.

The channel threshold is a signed 4-bit level. It is compared only against the most significant nibble of each sample.

A start pulse arms the block. Arming happens at once when the pretrigger fill is skipped. Otherwise the block waits until the pretrigger-done input reports that the pretrigger memory has filled. Once the event has fired, further conditions are ignored until the next start. An end-of-recording input returns the block to idle and, when enabled, raises a one-cycle interrupt request.

An optional trigger output pin repeats the event. The pin is held low whenever the mode follows the external input, because that connector then serves as an input.

Top module: `trig_detect`

## Requirements
- R1: After reset, trig_evt, trig_pin, armed, gate_open and irq are all low.
- R2: A start pulse with skip_pretrig high sets armed at the next clock edge. With skip_pretrig low, armed stays low until pretrig_done is seen high. At that edge armed rises. rec_done without start returns the block to idle (armed low). start wins over rec_done.
- R3: Mode code 0 (software) raises trig_evt at the first clock edge at which the block is armed, with no input condition.
- R4: Mode codes 1 to 4 are channel 0 rising, channel 0 falling, channel 1 rising and channel 1 falling. Let p be the signed top nibble (sample bits 7:4) of the previous cycle's sample and c that of the current one. A rising crossing is p < level and c >= level. A falling crossing is p >= level and c < level. The low four bits and the unselected channel have no effect.
- R5: Mode codes 5 and 6 fire on a rising or falling edge of ext_trig_in after a two-flop synchronizer. trig_evt appears at the third clock edge after the input changes.
- R6: Mode codes 7 and 8 drive gate_open high while armed and while the synchronized ext_trig_in is low (code 7) or high (code 8). These modes never raise trig_evt.
- R7: Mode codes 9 to 15 never raise trig_evt and never raise gate_open.
- R8: trig_evt is high for one cycle only. After it fires, the block leaves the armed state and ignores further conditions until the next start.
- R9: trig_pin equals trig_evt when trig_out_en is high, and stays low when trig_out_en is low. In mode codes 5 and 6 trig_pin stays low whatever trig_out_en is.
- R10: irq is high for one cycle, at the edge after rec_done is seen high with irq_en high. It stays low when irq_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, arms or re-arms the detector |
| skip_pretrig | input | 1 | Arm directly on start, without waiting for the pretrigger fill |
| pretrig_done | input | 1 | Pretrigger memory has been filled |
| rec_done | input | 1 | Recording finished; returns the block to idle |
| irq_en | input | 1 | Enables the end-of-recording interrupt |
| trig_out_en | input | 1 | Enables the trigger output pin |
| mode | input | 4 | Trigger mode code |
| level | input | 4 | Signed threshold, -8 to +7 |
| ch0_sample | input | 8 | Channel 0 sample |
| ch1_sample | input | 8 | Channel 1 sample |
| ext_trig_in | input | 1 | External logic-level trigger and gate input (asynchronous) |
| trig_evt | output | 1 | One-cycle trigger event |
| trig_pin | output | 1 | Trigger output pin |
| armed | output | 1 | Detector is armed and evaluating conditions |
| gate_open | output | 1 | Gated sampling is active |
| irq | output | 1 | One-cycle end-of-recording interrupt request |

## Verification
The channel modes are swept over every pair of previous and current top nibbles against every level, for both channels and both polarities. This separates signed from unsigned comparison, the >= boundary from >, and the selected channel from the other one, which always receives the opposite pattern.

The external-edge and gate modes are tried with all four before and after input values. These trials also measure the synchronizer latency, with a check one edge before the expected event.

Unused codes are driven with both edges and crossings present, to show that they stay quiet. Software mode is run with and without the pretrigger wait.

// File: rtl/trig_pkg.sv
package trig_pkg;
   localparam int MODE_W = 4;

   localparam logic [MODE_W-1:0] MD_SOFT     = 4'd0;
   localparam logic [MODE_W-1:0] MD_C0_RISE  = 4'd1;
   localparam logic [MODE_W-1:0] MD_C0_FALL  = 4'd2;
   localparam logic [MODE_W-1:0] MD_C1_RISE  = 4'd3;
   localparam logic [MODE_W-1:0] MD_C1_FALL  = 4'd4;
   localparam logic [MODE_W-1:0] MD_EXT_RISE = 4'd5;
   localparam logic [MODE_W-1:0] MD_EXT_FALL = 4'd6;
   localparam logic [MODE_W-1:0] MD_GATE_LO  = 4'd7;
   localparam logic [MODE_W-1:0] MD_GATE_HI  = 4'd8;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_WAIT_PRE = 2'd1,
      ST_ARMED    = 2'd2,
      ST_FIRED    = 2'd3
   } seq_state_t;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("trig_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= 1'b0;
         else        q_r <= d;
      end
      assign q = q_r;
   end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '0;
         else        sr <= {sr[STAGES-2:0], d};
      end
      assign q = sr[STAGES-1];
   end
endmodule

// File: rtl/trig_xing.sv
module trig_xing #(
   parameter int SAMPLE_W = 8,
   parameter int LEVEL_W  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [SAMPLE_W-1:0]        sample,
   input  logic signed [LEVEL_W-1:0]  level,
   output logic                       rise,
   output logic                       fall
);
   localparam int SHIFT = SAMPLE_W - LEVEL_W;

   logic signed [SAMPLE_W-1:0] smp_s;
   logic signed [LEVEL_W-1:0]  cur_nib;
   logic signed [LEVEL_W-1:0]  prev_nib;

   assign smp_s   = sample;
   assign cur_nib = LEVEL_W'(smp_s >>> SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_nib <= '0;
      else        prev_nib <= cur_nib;
   end

   assign rise = (prev_nib <  level) && (cur_nib >= level);
   assign fall = (prev_nib >= level) && (cur_nib <  level);
endmodule

// File: rtl/trig_seq.sv
module trig_seq
   import trig_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic skip_pre,
   input  logic pre_done,
   input  logic rec_done,
   input  logic irq_en,
   input  logic hit,
   output logic fire,
   output logic trig_evt,
   output logic armed,
   output logic irq
);
   seq_state_t state_q;

   assign armed = (state_q == ST_ARMED);
   assign fire  = armed && hit && !start && !rec_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         trig_evt <= 1'b0;
         irq      <= 1'b0;
      end else begin
         trig_evt <= fire;
         irq      <= rec_done && irq_en;
         if (start) begin
            state_q <= skip_pre ? ST_ARMED : ST_WAIT_PRE;
         end else if (rec_done) begin
            state_q <= ST_IDLE;
         end else begin
            unique case (state_q)
               ST_WAIT_PRE: if (pre_done) state_q <= ST_ARMED;
               ST_ARMED:    if (hit)      state_q <= ST_FIRED;
               default:     state_q <= state_q;
            endcase
         end
      end
   end
endmodule

// File: rtl/trig_detect.sv
module trig_detect
   import trig_pkg::*;
#(
   parameter int SAMPLE_W    = 8,
   parameter int LEVEL_W     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      skip_pretrig,
   input  logic                      pretrig_done,
   input  logic                      rec_done,
   input  logic                      irq_en,
   input  logic                      trig_out_en,
   input  logic [MODE_W-1:0]         mode,
   input  logic signed [LEVEL_W-1:0] level,
   input  logic [SAMPLE_W-1:0]       ch0_sample,
   input  logic [SAMPLE_W-1:0]       ch1_sample,
   input  logic                      ext_trig_in,
   output logic                      trig_evt,
   output logic                      trig_pin,
   output logic                      armed,
   output logic                      gate_open,
   output logic                      irq
);
   localparam int NUM_CH = 2;

   if (LEVEL_W < 2 || LEVEL_W > SAMPLE_W) begin : g_bad_level
      $error("trig_detect: LEVEL_W must lie in 2..SAMPLE_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("trig_detect: SYNC_STAGES must be at least 2");
   end

   logic [SAMPLE_W-1:0] smp_arr [NUM_CH];
   logic [NUM_CH-1:0]   ch_rise;
   logic [NUM_CH-1:0]   ch_fall;

   assign smp_arr[0] = ch0_sample;
   assign smp_arr[1] = ch1_sample;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      trig_xing #(
         .SAMPLE_W (SAMPLE_W),
         .LEVEL_W  (LEVEL_W)
      ) u_xing (
         .clk    (clk),
         .rst_n  (rst_n),
         .sample (smp_arr[c]),
         .level  (level),
         .rise   (ch_rise[c]),
         .fall   (ch_fall[c])
      );
   end

   logic ext_s;
   logic ext_d;
   logic ext_rise;
   logic ext_fall;

   trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_trig_in),
      .q     (ext_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_d <= 1'b0;
      else        ext_d <= ext_s;
   end

   assign ext_rise = ext_s && !ext_d;
   assign ext_fall = !ext_s && ext_d;

   logic hit;
   logic ext_mode;
   logic gate_lvl;

   always_comb begin
      hit      = 1'b0;
      ext_mode = 1'b0;
      gate_lvl = 1'b0;
      case (mode)
         MD_SOFT:     hit = 1'b1;
         MD_C0_RISE:  hit = ch_rise[0];
         MD_C0_FALL:  hit = ch_fall[0];
         MD_C1_RISE:  hit = ch_rise[1];
         MD_C1_FALL:  hit = ch_fall[1];
         MD_EXT_RISE: begin hit = ext_rise; ext_mode = 1'b1; end
         MD_EXT_FALL: begin hit = ext_fall; ext_mode = 1'b1; end
         MD_GATE_LO:  gate_lvl = !ext_s;
         MD_GATE_HI:  gate_lvl = ext_s;
         default:     hit = 1'b0;
      endcase
   end

   logic fire;

   trig_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .skip_pre (skip_pretrig),
      .pre_done (pretrig_done),
      .rec_done (rec_done),
      .irq_en   (irq_en),
      .hit      (hit),
      .fire     (fire),
      .trig_evt (trig_evt),
      .armed    (armed),
      .irq      (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_pin <= 1'b0;
      else        trig_pin <= fire && trig_out_en && !ext_mode;
   end

   assign gate_open = armed && gate_lvl;
endmodule

// File: rtl/trig_detect_chk.sv
module trig_detect_chk
   import trig_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              skip_pretrig,
   input logic              rec_done,
   input logic              irq_en,
   input logic [MODE_W-1:0] mode,
   input logic              trig_evt,
   input logic              trig_pin,
   input logic              armed,
   input logic              gate_open,
   input logic              irq
);
   assert_skip_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && skip_pretrig) |=> armed);

   assert_evt_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_evt |=> !trig_evt);

   assert_evt_from_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_evt |-> $past(armed));

   assert_unused_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trig_evt |-> ($past(mode) <= MD_GATE_HI));

   assert_gate_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      gate_open |-> armed);

   assert_pin_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pin |-> trig_evt);

   assert_pin_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pin |-> !($past(mode) == MD_EXT_RISE || $past(mode) == MD_EXT_FALL));

   assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(rec_done && irq_en));
endmodule

bind trig_detect trig_detect_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .skip_pretrig (skip_pretrig),
   .rec_done     (rec_done),
   .irq_en       (irq_en),
   .mode         (mode),
   .trig_evt     (trig_evt),
   .trig_pin     (trig_pin),
   .armed        (armed),
   .gate_open    (gate_open),
   .irq          (irq)
);

// File: tb/trig_detect_bench.sv
module trig_detect_bench;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              skip_pretrig = 1'b1;
   logic              pretrig_done = 1'b0;
   logic              rec_done = 1'b0;
   logic              irq_en = 1'b0;
   logic              trig_out_en = 1'b0;
   logic [3:0]        mode = 4'd0;
   logic signed [3:0] level = 4'sd0;
   logic [7:0]        ch0_sample = 8'd0;
   logic [7:0]        ch1_sample = 8'd0;
   logic              ext_trig_in = 1'b0;
   logic              trig_evt, trig_pin, armed, gate_open, irq;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   trig_detect u_trig_detect (
      .clk (clk), .rst_n (rst_n), .start (start), .skip_pretrig (skip_pretrig),
      .pretrig_done (pretrig_done), .rec_done (rec_done), .irq_en (irq_en),
      .trig_out_en (trig_out_en), .mode (mode), .level (level),
      .ch0_sample (ch0_sample), .ch1_sample (ch1_sample), .ext_trig_in (ext_trig_in),
      .trig_evt (trig_evt), .trig_pin (trig_pin), .armed (armed),
      .gate_open (gate_open), .irq (irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // return to idle, then arm with the pretrigger skipped
   task automatic idle_then_arm();
      rec_done = 1'b1; step();
      rec_done = 1'b0; skip_pretrig = 1'b1; start = 1'b1; step();
      start = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) step();
      // R1 reset state
      chk("R1 trig_evt", int'(trig_evt), 0);
      chk("R1 trig_pin", int'(trig_pin), 0);
      chk("R1 armed", int'(armed), 0);
      chk("R1 gate_open", int'(gate_open), 0);
      chk("R1 irq", int'(irq), 0);
      rst_n = 1'b1; step();

      // R3 software mode with skip, R9 pin follows
      mode = 4'd0; trig_out_en = 1'b1;
      start = 1'b1; skip_pretrig = 1'b1; step();
      start = 1'b0;
      chk("R2 armed after skip start", int'(armed), 1);
      chk("R3 no evt yet", int'(trig_evt), 0);
      step();
      chk("R3 software evt", int'(trig_evt), 1);
      chk("R9 pin with enable", int'(trig_pin), 1);
      chk("R8 disarmed after fire", int'(armed), 0);
      step();
      chk("R8 evt single cycle", int'(trig_evt), 0);

      // R2 pretrigger wait
      trig_out_en = 1'b0;
      start = 1'b1; skip_pretrig = 1'b0; step();
      start = 1'b0;
      repeat (4) step();
      chk("R2 waits for pretrigger", int'(armed), 0);
      chk("R2 no evt while waiting", int'(trig_evt), 0);
      pretrig_done = 1'b1; step();
      pretrig_done = 1'b0;
      chk("R2 armed after pretrig_done", int'(armed), 1);
      step();
      chk("R3 evt after pretrigger", int'(trig_evt), 1);
      chk("R9 pin low without enable", int'(trig_pin), 0);
      rec_done = 1'b1; step(); rec_done = 1'b0;
      chk("R2 rec_done returns idle", int'(armed), 0);

      // R4 channel sweep: every level, previous and current nibble
      for (int ch = 0; ch < 2; ch++) begin
         for (int pol = 0; pol < 2; pol++) begin
            for (int lv = -8; lv < 8; lv++) begin
               for (int pa = -8; pa < 8; pa++) begin
                  for (int cb = -8; cb < 8; cb++) begin
                     logic [3:0] pn, cn, lo;
                     bit exp;
                     pn = 4'(pa); cn = 4'(cb); lo = 4'(pa * 3 + cb);
                     mode  = 4'(1 + ch * 2 + pol);
                     level = 4'(lv);
                     trig_out_en = lo[0];
                     if (ch == 0) begin ch0_sample = {pn, lo}; ch1_sample = {cn, ~lo}; end
                     else         begin ch1_sample = {pn, lo}; ch0_sample = {cn, ~lo}; end
                     idle_then_arm();
                     if (ch == 0) begin ch0_sample = {cn, ~lo}; ch1_sample = {pn, lo}; end
                     else         begin ch1_sample = {cn, ~lo}; ch0_sample = {pn, lo}; end
                     step();
                     exp = (pol == 0) ? (pa < lv && cb >= lv) : (pa >= lv && cb < lv);
                     chk($sformatf("R4 ch%0d pol%0d lv%0d %0d->%0d", ch, pol, lv, pa, cb),
                         int'(trig_evt), int'(exp));
                     if (exp)
                        chk("R9 pin on channel evt", int'(trig_pin), int'(lo[0]));
                  end
               end
            end
         end
      end

      // R8 one-shot: a second crossing is ignored until re-armed
      mode = 4'd1; level = 4'sd0; ch0_sample = 8'hF0;
      idle_then_arm();
      ch0_sample = 8'h00; step();
      chk("R8 first crossing fires", int'(trig_evt), 1);
      ch0_sample = 8'hF0; step();
      ch0_sample = 8'h00; step();
      chk("R8 second crossing ignored", int'(trig_evt), 0);

      // R5 external edges, R9 pin blocked
      for (int m = 5; m < 7; m++) begin
         for (int v0 = 0; v0 < 2; v0++) begin
            for (int v1 = 0; v1 < 2; v1++) begin
               bit exp;
               mode = 4'(m); trig_out_en = 1'b1; ext_trig_in = v0[0];
               rec_done = 1'b1; repeat (4) step();
               idle_then_arm();
               ext_trig_in = v1[0];
               step(); step();
               chk("R5 no evt before sync latency", int'(trig_evt), 0);
               step();
               exp = (m == 5) ? (v0 == 0 && v1 == 1) : (v0 == 1 && v1 == 0);
               chk($sformatf("R5 mode%0d %0d->%0d", m, v0, v1), int'(trig_evt), int'(exp));
               chk("R9 pin blocked in external modes", int'(trig_pin), 0);
            end
         end
      end

      // R6 gate modes
      for (int m = 7; m < 9; m++) begin
         for (int v = 0; v < 2; v++) begin
            bit exp;
            mode = 4'(m); ext_trig_in = v[0];
            idle_then_arm();
            repeat (3) step();
            exp = (m == 8) ? (v == 1) : (v == 0);
            chk($sformatf("R6 mode%0d gate level %0d", m, v), int'(gate_open), int'(exp));
            chk("R6 gate mode no evt", int'(trig_evt), 0);
            rec_done = 1'b1; step(); rec_done = 1'b0;
            chk("R6 gate closed when idle", int'(gate_open), 0);
         end
      end

      // R7 unused codes stay quiet under edges and crossings
      for (int m = 9; m < 16; m++) begin
         int seen_evt, seen_gate;
         seen_evt = 0; seen_gate = 0;
         mode = 4'(m); level = 4'sd0; ch0_sample = 8'h80; ch1_sample = 8'h7F;
         ext_trig_in = 1'b0;
         idle_then_arm();
         ch0_sample = 8'h70; ch1_sample = 8'h80; ext_trig_in = 1'b1;
         for (int k = 0; k < 4; k++) begin
            step();
            seen_evt  += int'(trig_evt);
            seen_gate += int'(gate_open);
         end
         ext_trig_in = 1'b0;
         for (int k = 0; k < 4; k++) begin
            step();
            seen_evt  += int'(trig_evt);
            seen_gate += int'(gate_open);
         end
         chk($sformatf("R7 code %0d evt", m), seen_evt, 0);
         chk($sformatf("R7 code %0d gate", m), seen_gate, 0);
      end

      // R10 interrupt
      irq_en = 1'b1; rec_done = 1'b1; step();
      rec_done = 1'b0;
      chk("R10 irq raised", int'(irq), 1);
      step();
      chk("R10 irq one cycle", int'(irq), 0);
      irq_en = 1'b0; rec_done = 1'b1; step();
      rec_done = 1'b0;
      chk("R10 irq masked", int'(irq), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule